// File: doc/BRIEF.md
# Processor Low-Power Entry Controller

This block sits beside a fully static 16/32-bit processor and stops the processor's clock when software asks for a low-power state, then starts it again on request. It watches the processor bus. Software asks for low power with a supervisor write to a reserved address, which an external address decoder flags through `addr_match`, and then runs the STOP instruction. The controller counts bus cycles, starting with that write. When the last cycle of the STOP sequence ends, it closes the clock gate. A restart request or a reset request opens the gate again. Both requests are asynchronous and pass through a two-flop synchroniser on the free-running clock.

The controller is a three-state machine with these states:
- `ST_IDLE`: the clock runs and no write has armed the controller.
- `ST_ARMED`: the arming write has been seen and bus cycles are being counted.
- `ST_STOPPED`: the processor clock is held low.

Its transitions are:
- `T_ARM` (IDLE to ARMED): a qualifying write ends.
- `T_COUNT` (ARMED to ARMED): a later bus cycle ends before the count is complete.
- `T_ENTER` (ARMED to STOPPED): the last counted cycle ends.
- `T_WAKE` (STOPPED to IDLE): a synchronised restart or reset request.
- `T_CLEAR` (ARMED to IDLE): a synchronised reset request.

The number of bus cycles to count is the parameter `CYCLES`. Its default of 3 covers the arming write plus the two fetches of the STOP operand. If the bus is to be released to high impedance, the system bus arbiter must complete that hand-over during the operand fetch. It therefore happens before the clock stops.

The gate's enable is held in a latch that is open only while `clk` is low. As a result, `core_clk` never carries a shortened high pulse. The clock must be stable before a restart is requested.

Top module: `lp_entry_ctrl`

## Requirements
- R1: A bus cycle qualifies (arms the controller) only if, on some rising edge while `as_n` is low, all of the following hold: `rw_n` is 0 (write), `fc[2]` is 1 and `fc` is not 3'b111 (supervisor, not processor space), `addr_match` is 1, and at least one of `uds_n`/`lds_n` is 0.
- R2: A write that fails any condition of R1 leaves `lp_armed` and `lp_stopped` at 0 and the cycle counter at zero. A following run of non-qualifying cycles therefore never stops the clock.
- R3: A bus cycle ends on the first rising edge at which `as_n` is sampled 1 after being sampled 0, and the arming write counts as cycle 1. `lp_stopped` rises on the edge where cycle number `CYCLES` (default 3) ends, and `lp_armed` falls on that same edge.
- R4: `core_clk_en` is a copy of "not stopped" taken while `clk` is low. `core_clk` is `clk` AND `core_clk_en`. While stopped, `core_clk` has no rising edges; in any other state it follows `clk`.
- R5: `restart_req` is synchronised by two flops. If it is first sampled 1 on edge k while stopped, `lp_stopped` falls on edge k+2. The request has no effect in the idle or armed states, and the count already reached is kept.
- R6: `reset_req` is synchronised in the same way and with the same latency. It clears both the armed and stopped states and resets the counter. It takes priority over `restart_req`.
- R7: `lp_armed` is 1 from the edge of `T_ARM` until `T_ENTER` or `T_CLEAR`, and `lp_armed` and `lp_stopped` are never both 1.
- R8: While `rst_n` is low (asynchronous), the outputs are `lp_armed`=0, `lp_stopped`=0 and `core_clk_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| as_n | input | 1 | Address strobe, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Processor function code |
| addr_match | input | 1 | Decoder flag for the low-power address |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| restart_req | input | 1 | Asynchronous wake request, active high |
| reset_req | input | 1 | Asynchronous reset request, active high |
| core_clk | output | 1 | Gated processor clock |
| core_clk_en | output | 1 | Latched gate enable |
| lp_armed | output | 1 | Controller is counting the stop sequence |
| lp_stopped | output | 1 | Processor clock is stopped |

## Verification
The arming and stopping results change on the rising edge that first sees `as_n` high. The bench therefore drives `as_n` high at a falling edge and samples 1 ns after the next falling edge.

A restart or reset request raised just after a falling edge takes effect on the third rising edge that follows. The bench checks that the state still holds after the second edge and has changed after the third.

`core_clk_en` settles in the low phase after the state change, so it is sampled in the same window. Gating is also checked by counting `core_clk` rising edges over fixed windows, with the expected value 0 while stopped and 8 while running.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_STOPPED = 2'd2
    } lpe_state_t;

    localparam logic [2:0] FC_CPU_SPACE = 3'b111;

    // Supervisor access: high function-code bit set, excluding processor space.
    function automatic logic is_supervisor(input logic [2:0] code);
        return code[2] && (code != FC_CPU_SPACE);
    endfunction

endpackage

// File: rtl/lpe_sync.sv
module lpe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/lpe_bus_mon.sv
module lpe_bus_mon
    import lpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       rw_n,
    input  logic [2:0] fc,
    input  logic       addr_match,
    input  logic       uds_n,
    input  logic       lds_n,
    output logic       cyc_end,
    output logic       cyc_qual
);

    logic as_q;
    logic qual_q;
    logic qual_now;

    // A qualifying write: strobed, supervisor, decoder hit, some data lane active.
    assign qual_now = !as_n && !rw_n && is_supervisor(fc) && addr_match
                      && (!uds_n || !lds_n);

    assign cyc_end  = as_n && !as_q;
    assign cyc_qual = qual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q   <= 1'b1;
            qual_q <= 1'b0;
        end else begin
            as_q <= as_n;
            if (cyc_end)       qual_q <= 1'b0;
            else if (qual_now) qual_q <= 1'b1;
        end
    end

endmodule

// File: rtl/lpe_clk_gate.sv
module lpe_clk_gate (
    input  logic clk,
    input  logic en,
    output logic en_lat,
    output logic gclk
);

    // Transparent only in the low phase, so the enable never moves under a high pulse.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
    import lpe_pkg::*;
#(
    parameter int CYCLES      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       rw_n,
    input  logic [2:0] fc,
    input  logic       addr_match,
    input  logic       uds_n,
    input  logic       lds_n,
    input  logic       restart_req,
    input  logic       reset_req,
    output logic       core_clk,
    output logic       core_clk_en,
    output logic       lp_armed,
    output logic       lp_stopped
);

    localparam int               CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    lpe_state_t       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             cyc_end, cyc_qual;
    logic [1:0]       req_s;
    logic             restart_s, reset_s;
    logic             gate_en;

    lpe_bus_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_n       (as_n),
        .rw_n       (rw_n),
        .fc         (fc),
        .addr_match (addr_match),
        .uds_n      (uds_n),
        .lds_n      (lds_n),
        .cyc_end    (cyc_end),
        .cyc_qual   (cyc_qual)
    );

    lpe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({reset_req, restart_req}),
        .q     (req_s)
    );

    assign restart_s = req_s[0];
    assign reset_s   = req_s[1];

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // Transitions
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: begin
                if (reset_s) begin
                    cnt_n = '0;
                end else if (cyc_end && cyc_qual) begin          // T_ARM
                    if (CYCLES <= 1) begin
                        st_n  = ST_STOPPED;
                        cnt_n = '0;
                    end else begin
                        st_n  = ST_ARMED;
                        cnt_n = ONE;
                    end
                end
            end
            ST_ARMED: begin
                if (reset_s) begin                               // T_CLEAR
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else if (cyc_end) begin
                    if (cnt == LAST) begin                       // T_ENTER
                        st_n  = ST_STOPPED;
                        cnt_n = '0;
                    end else begin                               // T_COUNT
                        cnt_n = cnt + ONE;
                    end
                end
            end
            ST_STOPPED: begin
                if (reset_s || restart_s) begin                  // T_WAKE
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        lp_armed   = (st == ST_ARMED);
        lp_stopped = (st == ST_STOPPED);
        gate_en    = (st != ST_STOPPED);
    end

    lpe_clk_gate u_gate (
        .clk    (clk),
        .en     (gate_en),
        .en_lat (core_clk_en),
        .gclk   (core_clk)
    );

endmodule

// File: rtl/lp_entry_ctrl_chk.sv
module lp_entry_ctrl_chk #(
    parameter int CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic restart_req,
    input logic reset_req,
    input logic core_clk_en,
    input logic lp_armed,
    input logic lp_stopped
);

    // R7: the two states are exclusive
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_armed && lp_stopped));

    // R4: latched enable seen at an edge reflects the state held before it
    p_gate_tracks_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en == !lp_stopped);

    // R3: arming happens only at the end of a bus cycle
    p_arm_at_cycle_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_armed) |-> ($past(as_n) && !$past(as_n, 2)));

    // R3: stopping happens only at the end of a bus cycle
    p_stop_at_cycle_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_stopped) |-> ($past(as_n) && !$past(as_n, 2)));

    // R7: with more than one cycle to count, the stop is entered from the armed state
    p_stop_from_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lp_stopped) && (CYCLES > 1)) |-> $past(lp_armed));

    // R5: leaving the stopped state needs a synchronised request
    p_wake_needs_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_stopped) |-> ($past(restart_req, 3) || $past(reset_req, 3)));

    // R6: a sampled reset request clears both states after the synchroniser
    p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reset_req, 3) |-> (!lp_armed && !lp_stopped));

endmodule

bind lp_entry_ctrl lp_entry_ctrl_chk #(.CYCLES(CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_n        (as_n),
    .restart_req (restart_req),
    .reset_req   (reset_req),
    .core_clk_en (core_clk_en),
    .lp_armed    (lp_armed),
    .lp_stopped  (lp_stopped)
);

// File: tb/lp_entry_ctrl_test.sv
module lp_entry_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       as_n = 1'b1;
    logic       rw_n = 1'b1;
    logic [2:0] fc = 3'b000;
    logic       addr_match = 1'b0;
    logic       uds_n = 1'b1;
    logic       lds_n = 1'b1;
    logic       restart_req = 1'b0;
    logic       reset_req = 1'b0;
    logic       core_clk, core_clk_en, lp_armed, lp_stopped;

    int checks = 0;
    int errors = 0;
    int core_edges = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge core_clk) core_edges++;

    lp_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw_n(rw_n), .fc(fc),
        .addr_match(addr_match), .uds_n(uds_n), .lds_n(lds_n),
        .restart_req(restart_req), .reset_req(reset_req),
        .core_clk(core_clk), .core_clk_en(core_clk_en),
        .lp_armed(lp_armed), .lp_stopped(lp_stopped)
    );

    // {fc[2:0], rw_n, addr_match, strobe_active, expected_armed}
    localparam logic [6:0] VEC [8] = '{
        {3'b101, 1'b0, 1'b1, 1'b1, 1'b1},   // supervisor data write
        {3'b110, 1'b0, 1'b1, 1'b1, 1'b1},   // supervisor program space write
        {3'b001, 1'b0, 1'b1, 1'b1, 1'b0},   // user write
        {3'b010, 1'b0, 1'b1, 1'b1, 1'b0},   // user program write
        {3'b101, 1'b1, 1'b1, 1'b1, 1'b0},   // supervisor read
        {3'b101, 1'b0, 1'b0, 1'b1, 1'b0},   // no decoder hit
        {3'b101, 1'b0, 1'b1, 1'b0, 1'b0},   // no data strobe
        {3'b111, 1'b0, 1'b1, 1'b1, 1'b0}    // processor space
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One bus cycle; returns 1 ns after the falling edge that follows the cycle-end edge.
    task automatic bus_cycle(input logic [2:0] f, input logic rw, input logic m, input logic ds);
        @(negedge clk);
        as_n = 1'b0; fc = f; rw_n = rw; addr_match = m; uds_n = !ds; lds_n = !ds;
        @(negedge clk);
        as_n = 1'b1; rw_n = 1'b1; addr_match = 1'b0; uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic arm_write();
        bus_cycle(3'b101, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic read_cycle();
        bus_cycle(3'b110, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic edges_over_window(input string tag, input int exp);
        int start;
        start = core_edges;
        repeat (8) @(negedge clk);
        #1;
        chk(tag, core_edges - start, exp);
    endtask

    initial begin
        // R8: block reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R8 armed in reset", int'(lp_armed), 0);
        chk("R8 stopped in reset", int'(lp_stopped), 0);
        chk("R8 gate enable in reset", int'(core_clk_en), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: qualification table
        for (int i = 0; i < 8; i++) begin
            bus_cycle(VEC[i][6:4], VEC[i][3], VEC[i][2], VEC[i][1]);
            chk($sformatf("R1 R2 vector %0d armed", i), int'(lp_armed), int'(VEC[i][0]));
            if (VEC[i][0]) begin
                reset_req = 1'b1;
                repeat (3) @(negedge clk);
                #1;
                reset_req = 1'b0;
                chk($sformatf("R6 vector %0d cleared", i), int'(lp_armed), 0);
            end
        end

        // R3 / R7: count of three cycles, then stop
        arm_write();
        chk("R7 armed after arming write", int'(lp_armed), 1);
        read_cycle();
        chk("R3 not stopped after two cycles", int'(lp_stopped), 0);
        chk("R7 still armed after two cycles", int'(lp_armed), 1);
        read_cycle();
        chk("R3 stopped after third cycle", int'(lp_stopped), 1);
        chk("R7 armed drops on stop", int'(lp_armed), 0);
        chk("R4 gate enable low while stopped", int'(core_clk_en), 0);
        edges_over_window("R4 no core edges while stopped", 0);

        // R5: restart latency
        restart_req = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R5 still stopped after two edges", int'(lp_stopped), 1);
        @(negedge clk);
        #1;
        chk("R5 running after third edge", int'(lp_stopped), 0);
        chk("R4 gate enable back high", int'(core_clk_en), 1);
        restart_req = 1'b0;
        edges_over_window("R4 core edges while running", 8);

        // R2: rejected write leaves counter at zero
        bus_cycle(3'b001, 1'b0, 1'b1, 1'b1);
        read_cycle();
        read_cycle();
        chk("R2 no stop after rejected write", int'(lp_stopped), 0);
        chk("R2 not armed after rejected write", int'(lp_armed), 0);

        // R5: restart ignored while armed, count kept
        arm_write();
        restart_req = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        restart_req = 1'b0;
        chk("R5 restart ignored while armed", int'(lp_armed), 1);
        read_cycle();
        read_cycle();
        chk("R5 count kept across restart", int'(lp_stopped), 1);

        // R6: reset request wakes from stop with same latency
        reset_req = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R6 still stopped after two edges", int'(lp_stopped), 1);
        @(negedge clk);
        #1;
        chk("R6 reset wakes on third edge", int'(lp_stopped), 0);
        reset_req = 1'b0;

        // R6: priority over restart, counter cleared
        arm_write();
        read_cycle();
        reset_req = 1'b1;
        restart_req = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        reset_req = 1'b0;
        restart_req = 1'b0;
        chk("R6 reset wins over restart", int'(lp_armed), 0);
        repeat (3) @(negedge clk);
        read_cycle();
        read_cycle();
        chk("R6 counter cleared by reset", int'(lp_stopped), 0);

        // R8: asynchronous block reset while armed
        arm_write();
        #2;
        rst_n = 1'b0;
        #1;
        chk("R8 async reset clears armed", int'(lp_armed), 0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog R3: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule